// File: doc/BRIEF.md
# Receive Buffer Flow-Control Counter

This block tracks, for each pair of DMA channels, how many receive buffers software has handed to the receive engine and not yet seen consumed. Channels are grouped in even/odd pairs; a pair's slot index is its channel number shifted right by one, and each slot has its own counter, its own pair of thresholds and its own consume input. Software returns buffers by writing an increment to the slot's allocation register. The receive engine pulses the slot's consume input once for every buffer it fills.

Each slot raises a pause indication when its count falls below a programmable low threshold. It drops the indication only when the count has climbed back to a programmable high threshold, so the indication has hysteresis. A force bit in the allocation register returns the slot to idle with a zero count. Software usually sets the low threshold to about a third of the ring size and the high threshold to about two thirds. A per-slot enable bit in a global configuration word turns each slot on or off.

All register state, counts and pause outputs update on the rising clock edge that follows the write or consume pulse. Register reads are combinational from the address.

Top module: `rx_fc_counter`

## Requirements
- R1: After reset every count is 0, every pause output is 0, and the configuration, threshold and allocation registers all read as 0.
- R2: The configuration word sits at offset 0x00. Bit 0 is the controller enable, bit n+1 is the enable of slot n, and bits 27:24 hold a 4-bit channel count. These bits read back as written and all other bits read as 0. Slot n has its low threshold at 0x04+12n and its high threshold at 0x08+12n, and each keeps the low CNT_W bits of the written data.
- R3: A write to slot n's allocation register at 0x0C+12n with bit 31 clear adds the low CNT_W bits of the data to that slot's count. Reading the allocation register returns the current count.
- R4: A write to an allocation register with bit 31 set clears that slot's count and pause on the next edge, whether or not the slot is enabled.
- R5: Each consume pulse on an enabled slot decrements its count by one, and the count stays at 0 when it is already 0. An increment and a consume in the same cycle apply together, so adding k while consuming gives count+k-1.
- R6: An increment that would pass 2^CNT_W-1 leaves the count at 2^CNT_W-1.
- R7: On an enabled slot, pause is 1 after any edge at which the new count is below the low threshold.
- R8: On an enabled slot, pause goes to 0 only when the new count is at or above the high threshold. For counts between the two thresholds it keeps its previous value.
- R9: While a slot's enable bit is 0, its pause reads 0 from the next edge on. Its count ignores increments and consume pulses.
- R10: Writes and consume pulses for one slot leave every other slot's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Register byte offset for writes and reads |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Read data for regAddr (combinational) |
| consume | input | NUM_SLOTS | One-cycle pulse per buffer filled, one bit per slot |
| pause | output | NUM_SLOTS | Flow-control pause, one bit per slot |

## Verification
The assertions check on every cycle that a force write leaves a zero count and a low pause, that a disabled slot keeps its count and drops pause, and that a consume on an empty slot cannot wrap the count. They also check that pause rises only below the low threshold, falls only at or above the high threshold, and that at most one slot is incremented per write. The directed scenarios are needed for the rest: the exact register layout and readback truncation, the hold behaviour between thresholds, the net result of simultaneous increment and consume, saturation at the top, and the isolation of one slot from another.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  // Strobes from register control to one slot datapath
  typedef struct packed {
    logic slotEn;
    logic addStb;
    logic forceStb;
  } slotCtl_t;

  localparam int FORCE_BIT   = 31;
  localparam int CHCNT_LSB   = 24;
  localparam int CHCNT_W     = 4;
  localparam int SLOT_STRIDE = 12;

  function automatic int loOffset(input int s);
    return 4 + SLOT_STRIDE * s;
  endfunction

  function automatic int hiOffset(input int s);
    return 8 + SLOT_STRIDE * s;
  endfunction

  function automatic int allocOffset(input int s);
    return 12 + SLOT_STRIDE * s;
  endfunction

endpackage

// File: rtl/rxfc_regs.sv
module rxfc_regs
  import rxfc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                regWrEn,
  input  logic [ADDR_W-1:0]                   regAddr,
  input  logic [DATA_W-1:0]                   regWrData,
  output logic [DATA_W-1:0]                   regRdData,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0]     slotCount,
  output slotCtl_t [NUM_SLOTS-1:0]            slotCtl,
  output logic [CNT_W-1:0]                    addVal,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0]     loThr,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0]     hiThr
);

  localparam logic [ADDR_W-1:0] CFG_ADDR = '0;

  logic                 ctrlEn;
  logic [NUM_SLOTS-1:0] slotEnR;
  logic [CHCNT_W-1:0]   chanCnt;
  logic [NUM_SLOTS-1:0] addVec;
  logic                 unusedWrBits;

  assign unusedWrBits = ^regWrData;
  assign addVal       = regWrData[CNT_W-1:0];

  wire cfgWr = regWrEn && (regAddr == CFG_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      slotEnR <= '0;
      chanCnt <= '0;
    end else if (cfgWr) begin
      ctrlEn  <= regWrData[0];
      slotEnR <= regWrData[NUM_SLOTS:1];
      chanCnt <= regWrData[CHCNT_LSB +: CHCNT_W];
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(loOffset(s));
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(hiOffset(s));
    localparam logic [ADDR_W-1:0] AL_A = ADDR_W'(allocOffset(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loThr[s] <= '0;
        hiThr[s] <= '0;
      end else if (regWrEn) begin
        if (regAddr == LO_A) loThr[s] <= regWrData[CNT_W-1:0];
        if (regAddr == HI_A) hiThr[s] <= regWrData[CNT_W-1:0];
      end
    end

    wire allocWr = regWrEn && (regAddr == AL_A);
    assign addVec[s]           = allocWr && !regWrData[FORCE_BIT];
    assign slotCtl[s].addStb   = addVec[s];
    assign slotCtl[s].forceStb = allocWr && regWrData[FORCE_BIT];
    assign slotCtl[s].slotEn   = slotEnR[s];
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CFG_ADDR) begin
      regRdData[0]                    = ctrlEn;
      regRdData[NUM_SLOTS:1]          = slotEnR;
      regRdData[CHCNT_LSB +: CHCNT_W] = chanCnt;
    end
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (regAddr == ADDR_W'(loOffset(s)))    regRdData[CNT_W-1:0] = loThr[s];
      if (regAddr == ADDR_W'(hiOffset(s)))    regRdData[CNT_W-1:0] = hiThr[s];
      if (regAddr == ADDR_W'(allocOffset(s))) regRdData[CNT_W-1:0] = slotCount[s];
    end
  end

  AST_ONE_SLOT_ADD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(addVec)); // R10

endmodule

// File: rtl/rxfc_slot.sv
module rxfc_slot
  import rxfc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotCtl_t         ctl,
  input  logic [CNT_W-1:0] addVal,
  input  logic             consume,
  input  logic [CNT_W-1:0] loThr,
  input  logic [CNT_W-1:0] hiThr,
  output logic [CNT_W-1:0] count,
  output logic             pause
);

  localparam logic [CNT_W:0] MAX_WIDE = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W:0]   sumWide;
  logic [CNT_W:0]   decWide;
  logic [CNT_W-1:0] nxtCnt;

  always_comb begin
    sumWide = {1'b0, count} + (ctl.addStb ? {1'b0, addVal} : '0);
    if (consume && (sumWide != '0)) decWide = sumWide - 1'b1;
    else                            decWide = sumWide;
    nxtCnt = (decWide > MAX_WIDE) ? MAX_WIDE[CNT_W-1:0] : decWide[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      pause <= 1'b0;
    end else if (ctl.forceStb) begin
      count <= '0;
      pause <= 1'b0;
    end else if (ctl.slotEn) begin
      count <= nxtCnt;
      if (nxtCnt < loThr)       pause <= 1'b1;
      else if (nxtCnt >= hiThr) pause <= 1'b0;
    end else begin
      pause <= 1'b0;
    end
  end

  AST_FORCE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceStb |=> (count == '0) && !pause); // R4

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.slotEn && !ctl.forceStb) |=> $stable(count) && !pause); // R9

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.slotEn && consume && (count == '0) && !ctl.addStb) |=> (count == '0)); // R5

  AST_PAUSE_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pause) |-> (count < $past(loThr))); // R7

  AST_RESUME_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pause) && $past(ctl.slotEn) && !$past(ctl.forceStb)) |-> (count >= $past(hiThr))); // R8

endmodule

// File: rtl/rx_fc_counter.sv
module rx_fc_counter
  import rxfc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_SLOTS-1:0] consume,
  output logic [NUM_SLOTS-1:0] pause
);

  slotCtl_t [NUM_SLOTS-1:0]        slotCtl;
  logic [CNT_W-1:0]                addVal;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] loThr;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] hiThr;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] slotCount;

  rxfc_regs #(
    .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .slotCount(slotCount),
    .slotCtl(slotCtl), .addVal(addVal), .loThr(loThr), .hiThr(hiThr)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dp
    rxfc_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rstN(rstN), .ctl(slotCtl[s]), .addVal(addVal),
      .consume(consume[s]), .loThr(loThr[s]), .hiThr(hiThr[s]),
      .count(slotCount[s]), .pause(pause[s])
    );
  end

endmodule

// File: tb/rx_fc_counter_tb.sv
module rx_fc_counter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NS-1:0] consume = '0;
  logic [NS-1:0] pause;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fc_counter u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .consume(consume), .pause(pause)
  );

  function automatic logic [7:0] loA(int s); return 8'(4 + 12*s); endfunction
  function automatic logic [7:0] hiA(int s); return 8'(8 + 12*s); endfunction
  function automatic logic [7:0] alA(int s); return 8'(12 + 12*s); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic eat(input logic [NS-1:0] m);
    @(negedge clk);
    consume = m;
    @(negedge clk);
    consume = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 cfg reset", d, 0);
    rd(loA(2), d); chk("R1 lo reset", d, 0);
    rd(alA(0), d); chk("R1 count reset", d, 0);
    chk("R1 pause reset", 32'(pause), 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(8'h00, 32'hF500_003F);
    rd(8'h00, d); chk("R2 cfg readback", d, 32'h0500_001F);
    wr(loA(1), 32'h0000_0123);
    rd(loA(1), d); chk("R2 lo slot1 truncated", d, 32'h23);
    wr(hiA(1), 32'h0000_0040);
    rd(hiA(1), d); chk("R2 hi slot1", d, 32'h40);
    rd(loA(0), d); chk("R2 lo slot0 untouched", d, 0);
  endtask

  task automatic t_hyst();
    logic [31:0] d;
    wr(loA(0), 2);
    wr(hiA(0), 4);
    wr(8'h00, 32'h1F);
    tick();
    chk("R7 pause at empty", 32'(pause[0]), 1);
    wr(alA(0), 3);
    rd(alA(0), d); chk("R3 add 3", d, 3);
    chk("R8 hold between", 32'(pause[0]), 1);
    wr(alA(0), 1);
    rd(alA(0), d); chk("R3 add 1", d, 4);
    chk("R8 resume at high", 32'(pause[0]), 0);
    eat(4'b0001);
    rd(alA(0), d); chk("R5 consume to 3", d, 3);
    chk("R8 hold low side", 32'(pause[0]), 0);
    eat(4'b0001);
    chk("R8 hold at low", 32'(pause[0]), 0);
    eat(4'b0001);
    rd(alA(0), d); chk("R5 consume to 1", d, 1);
    chk("R7 pause below low", 32'(pause[0]), 1);
    eat(4'b0001);
    eat(4'b0001);
    rd(alA(0), d); chk("R5 floor at zero", d, 0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = alA(0); regWrData = 2; consume = 4'b0001;
    @(negedge clk);
    regWrEn = 1'b0; consume = '0;
    rd(alA(0), d); chk("R5 add and consume together", d, 1);
  endtask

  task automatic t_force();
    logic [31:0] d;
    wr(alA(0), 32'h8000_0000);
    rd(alA(0), d); chk("R4 force clears count", d, 0);
    chk("R4 force clears pause", 32'(pause[0]), 0);
    wr(alA(2), 5);
    wr(8'h00, 32'h17);
    wr(alA(2), 32'h8000_0001);
    rd(alA(2), d); chk("R4 force while disabled", d, 0);
    wr(8'h00, 32'h1F);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(alA(1), 10);
    chk("R7 slot1 paused", 32'(pause[1]), 1);
    wr(8'h00, 32'h1B);
    tick();
    chk("R9 pause dropped when off", 32'(pause[1]), 0);
    wr(alA(1), 5);
    rd(alA(1), d); chk("R9 add ignored when off", d, 10);
    eat(4'b0010);
    rd(alA(1), d); chk("R9 consume ignored when off", d, 10);
    chk("R9 pause stays low", 32'(pause[1]), 0);
    wr(8'h00, 32'h1F);
    tick();
    chk("R7 pause back after enable", 32'(pause[1]), 1);
  endtask

  task automatic t_sat();
    logic [31:0] d;
    wr(alA(3), 200);
    wr(alA(3), 100);
    rd(alA(3), d); chk("R6 saturate at top", d, 255);
    eat(4'b1000);
    rd(alA(3), d); chk("R5 consume from top", d, 254);
  endtask

  task automatic t_indep();
    logic [31:0] d;
    wr(alA(2), 7);
    rd(alA(2), d); chk("R10 slot2 add", d, 7);
    rd(alA(0), d); chk("R10 slot0 untouched", d, 0);
    rd(alA(3), d); chk("R10 slot3 untouched", d, 254);
    eat(4'b1000);
    rd(alA(2), d); chk("R10 slot2 ignores slot3 consume", d, 7);
    rd(alA(3), d); chk("R10 slot3 consumed", d, 253);
    rd(alA(1), d); chk("R10 slot1 untouched", d, 10);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    rstN = 1'b1;
    tick();
    t_reset();
    t_regmap();
    t_hyst();
    t_force();
    t_disable();
    t_sat();
    t_indep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule